// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block holds the configuration word array of a programmable logic device and serves it, flattened, to the logic fabric. A device programmer reaches it through a command port with a valid strobe, an opcode, an address and a data word. There are five opcodes: write a word, read a word back, clear the whole array, set the security lock, and no-op. The unprogrammed (blank) value of a word is all ones, because every fuse reads as disconnected. Each word also carries a written flag. A word can be written once between two full clears.

Setting the lock hides the contents. While the lock is set, every readback returns the blank word, and the preload-inhibit output that goes to the macrocells is high. The configuration outputs still carry the real data. Only a full clear of the array removes the lock, and it is released in the same cycle the clear finishes. A write issued while the lock is set starts an automatic clear of the whole array and then stores the word. The programmer never has to send a separate clear before a new pattern.

Top module: `cfgstore_top`

## Requirements
- R1: After reset every word reads as all ones in `cfg_bits`, and `locked`, `preload_inhibit`, `busy`, `done` and `err` are all low.
- R2: A write (opcode 1) to an unwritten word while unlocked stores the data. A read (opcode 2) raises `rd_valid` for one cycle, one clock after it is accepted, with the stored word on `rd_data`.
- R3: A write to a word that is already written, with no clear in between, pulses `err` for one cycle one clock after acceptance and leaves the word unchanged.
- R4: A clear (opcode 3) keeps `busy` high for exactly 2^ADDR_W cycles, blanking one word per cycle. `done` pulses for one cycle as `busy` falls. Afterwards every word is blank and writable again.
- R5: The lock command (opcode 4) raises `locked` and `preload_inhibit` one clock after acceptance.
- R6: While locked, every read returns all ones on `rd_data`, whatever is stored.
- R7: `locked` falls only in the cycle where `done` is high after a full clear. Read and repeated lock commands leave it set.
- R8: A write while locked clears the whole array, then stores the word. `busy` stays high for 2^ADDR_W+1 cycles, and `done` pulses at the end with `locked` low. Only the addressed word holds data afterwards.
- R9: A command presented while `busy` is high is not accepted and has no effect.
- R10: `cfg_bits` carries word i at bits [i*DATA_W +: DATA_W] at all times, whether or not the lock is set.
- R11: Opcodes 0, 5, 6 and 7 change nothing and produce no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns the store to blank and unlocked |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_op | input | 3 | Opcode: 1 write, 2 read, 3 clear, 4 lock, others no-op |
| cmd_addr | input | ADDR_W | Word address |
| cmd_data | input | DATA_W | Write data |
| busy | output | 1 | A clear sequence is running |
| done | output | 1 | One-cycle pulse when a clear sequence ends |
| err | output | 1 | One-cycle pulse for a rejected rewrite |
| rd_valid | output | 1 | Readback data valid |
| rd_data | output | DATA_W | Readback word, masked to blank while locked |
| locked | output | 1 | Security lock status |
| preload_inhibit | output | 1 | Blocks register preload in the macrocells |
| cfg_bits | output | 2^ADDR_W*DATA_W | Flattened configuration array |

## Verification
Three events can land on the same clock edge: blanking the last word, releasing the lock and pulsing `done`. Reads can also arrive right after a lock change. The bench locks the store, starts a clear, and at the negedge where `busy` first reads low it expects `done` high and `locked` low together. Its next read must then return a blank word that is not masked. A locked write exercises the same release one cycle later, after the extra store cycle. A write injected during a clear must leave its word blank.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PROG   = 3'd1,
    OP_READ   = 3'd2,
    OP_ERASE  = 3'd3,
    OP_SECURE = 3'd4
  } cfg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PEND  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/cfg_array.sv
module cfg_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clr_en,
  input  logic [ADDR_W-1:0]       clr_addr,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_word,
  output logic                    rd_written,
  output logic [DEPTH*DATA_W-1:0] cfg_bits
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  wrt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      wrt_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clr_en && clr_addr == ADDR_W'(i)) begin
          mem_q[i] <= '1;
          wrt_q[i] <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_W'(i)) begin
          mem_q[i] <= wr_data;
          wrt_q[i] <= 1'b1;
        end
      end
    end
  end

  assign rd_word    = mem_q[rd_addr];
  assign rd_written = wrt_q[rd_addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign cfg_bits[g*DATA_W +: DATA_W] = mem_q[g];
  end
endmodule

// File: rtl/cfg_lock.sv
module cfg_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lock,
  input  logic clr_lock,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (clr_lock) locked <= 1'b0;
    else if (set_lock) locked <= 1'b1;
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfgstore_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              locked,
  input  logic              addr_written,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_fire,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              clr_en,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              set_lock,
  output logic              clr_lock
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              pend_q, pend_d;
  logic              err_d, done_d, accept, start_erase;

  assign accept = cmd_valid && (st_q == ST_IDLE);
  assign busy   = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q; pend_d = pend_q;
    err_d = 1'b0; done_d = 1'b0; rd_fire = 1'b0; start_erase = 1'b0;
    wr_en = 1'b0; wr_addr = cmd_addr; wr_data = cmd_data;
    clr_en = 1'b0; clr_addr = ptr_q;
    set_lock = 1'b0; clr_lock = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        case (cmd_op)
          OP_PROG: begin
            if (locked) begin
              start_erase = 1'b1; pend_d = 1'b1; st_d = ST_ERASE;
            end else if (addr_written) begin
              err_d = 1'b1;
            end else begin
              wr_en = 1'b1;
            end
          end
          OP_READ:   rd_fire = 1'b1;
          OP_ERASE:  begin start_erase = 1'b1; pend_d = 1'b0; st_d = ST_ERASE; end
          OP_SECURE: set_lock = 1'b1;
          default: ;
        endcase
      end
      ST_ERASE: begin
        clr_en = 1'b1;
        if (ptr_q == LAST) begin
          if (pend_q) st_d = ST_PEND;
          else begin st_d = ST_IDLE; clr_lock = 1'b1; done_d = 1'b1; end
        end
      end
      ST_PEND: begin
        wr_en = 1'b1; wr_addr = pend_addr_q; wr_data = pend_data_q;
        clr_lock = 1'b1; done_d = 1'b1; pend_d = 1'b0; st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ptr_q <= '0; pend_q <= 1'b0;
      pend_addr_q <= '0; pend_data_q <= '0;
      err <= 1'b0; done <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      err    <= err_d;
      done   <= done_d;
      if (start_erase) begin
        ptr_q <= '0; pend_addr_q <= cmd_addr; pend_data_q <= cmd_data;
      end else if (clr_en) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgstore_top.sv
module cfgstore_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cmd_valid,
  input  logic [2:0]                          cmd_op,
  input  logic [ADDR_W-1:0]                   cmd_addr,
  input  logic [DATA_W-1:0]                   cmd_data,
  output logic                                busy,
  output logic                                done,
  output logic                                err,
  output logic                                rd_valid,
  output logic [DATA_W-1:0]                   rd_data,
  output logic                                locked,
  output logic                                preload_inhibit,
  output logic [(1<<ADDR_W)*DATA_W-1:0]       cfg_bits
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] mask_read(input logic lk, input logic [DATA_W-1:0] w);
    return lk ? {DATA_W{1'b1}} : w;
  endfunction

  logic              rd_fire, wr_en, clr_en, set_lock, clr_lock, addr_written;
  logic [ADDR_W-1:0] wr_addr, clr_addr;
  logic [DATA_W-1:0] wr_data, rd_word;

  cfg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .locked(locked),
    .addr_written(addr_written), .busy(busy), .done(done), .err(err),
    .rd_fire(rd_fire), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_en(clr_en), .clr_addr(clr_addr), .set_lock(set_lock), .clr_lock(clr_lock)
  );

  cfg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_en(clr_en), .clr_addr(clr_addr), .rd_addr(cmd_addr),
    .rd_word(rd_word), .rd_written(addr_written), .cfg_bits(cfg_bits)
  );

  cfg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .set_lock(set_lock), .clr_lock(clr_lock), .locked(locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= mask_read(locked, rd_word);
    end
  end

  assign preload_inhibit = locked;

  if (DEPTH < 2) begin : g_bad_depth
    initial $error("cfgstore_top needs at least two words");
  end
endmodule

// File: rtl/cfgstore_chk.sv
module cfgstore_chk
  import cfgstore_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              locked
);
  assert_masked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(locked)) |-> (rd_data == {DATA_W{1'b1}}));

  assert_unlock_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !locked));

  assert_err_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && !busy && cmd_op == OP_PROG));

  assert_read_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !busy && cmd_op == OP_READ));

  assert_lock_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmd_valid && !busy && cmd_op == OP_SECURE));
endmodule

bind cfgstore_top cfgstore_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .err(err), .rd_valid(rd_valid),
  .rd_data(rd_data), .locked(locked)
);

// File: tb/sim_cfgstore_top.sv
module sim_cfgstore_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic busy, done, err, rd_valid, locked, preload_inhibit;
  logic [DW-1:0] rd_data;
  logic [N*DW-1:0] cfg_bits;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [DW-1:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgstore_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done),
    .err(err), .rd_valid(rd_valid), .rd_data(rd_data), .locked(locked),
    .preload_inhibit(preload_inhibit), .cfg_bits(cfg_bits)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic read_chk(input int a, input logic [DW-1:0] exp, input string req);
    issue(3'd2, a, '0);
    chk(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
  endtask

  task automatic cfg_chk(input string req);
    for (int i = 0; i < N; i++)
      chk(cfg_bits[i*DW +: DW] === model[i], req, cfg_bits[i*DW +: DW], model[i]);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy === 1'b1) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < N; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && err === 0, "R1 idle flags", {busy, done, err}, 0);
    chk(locked === 0 && preload_inhibit === 0, "R1 unlocked", {locked, preload_inhibit}, 0);
    cfg_chk("R1 blank array");

    // R2 write every word, then read each back
    for (int i = 0; i < N; i++) begin
      issue(3'd1, i, pat(i)); model[i] = pat(i);
      chk(err === 0, "R2 no error on blank write", err, 0);
    end
    for (int i = 0; i < N; i++) read_chk(i, model[i], "R2 readback");
    cfg_chk("R10 flat layout");

    // R3 rewrite rejected
    issue(3'd1, 3, 8'h00);
    chk(err === 1, "R3 err pulse", err, 1);
    @(negedge clk);
    chk(err === 0, "R3 err single cycle", err, 0);
    read_chk(3, model[3], "R3 word unchanged");

    // R11 reserved opcodes
    for (int op = 5; op < 8; op++) begin
      issue(3'(op), 1, 8'h00);
      chk(rd_valid === 0 && busy === 0 && locked === 0, "R11 no effect", {rd_valid, busy, locked}, 0);
    end
    issue(3'd0, 2, 8'h00);
    chk(rd_valid === 0 && err === 0, "R11 nop", {rd_valid, err}, 0);
    cfg_chk("R11 array unchanged");

    // R5 lock, R6 masked reads, R10 data still present
    issue(3'd4, 0, '0);
    chk(locked === 1 && preload_inhibit === 1, "R5 lock set", {locked, preload_inhibit}, 3);
    for (int i = 0; i < N; i++) read_chk(i, '1, "R6 masked read");
    cfg_chk("R10 data while locked");
    issue(3'd4, 0, '0);
    chk(locked === 1, "R7 relock keeps lock", locked, 1);

    // R4 clear, R7 release with done, R9 injected command ignored
    issue(3'd3, 0, '0);
    chk(busy === 1, "R4 busy after clear", busy, 1);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = AW'(2); cmd_data = 8'h11;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    wait_idle(n);
    n = n + 1;
    chk(n == N, "R4 busy length", n, N);
    chk(done === 1 && locked === 0, "R7 done with unlock", {done, locked}, 2);
    @(negedge clk);
    chk(done === 0, "R4 done single cycle", done, 0);
    for (int i = 0; i < N; i++) model[i] = '1;
    cfg_chk("R4 array blank");
    read_chk(2, '1, "R9 write during clear ignored");
    read_chk(7, '1, "R7 unmasked blank read");
    issue(3'd1, 3, 8'h3C); model[3] = 8'h3C;
    chk(err === 0, "R4 rewrite allowed after clear", err, 0);
    read_chk(3, 8'h3C, "R4 rewrite stored");

    // R8 write while locked triggers automatic clear
    for (int i = 0; i < N; i++) if (i != 3) begin issue(3'd1, i, pat(i)); model[i] = pat(i); end
    issue(3'd4, 0, '0);
    issue(3'd1, 5, 8'h5A);
    wait_idle(n);
    chk(n == N + 1, "R8 busy length", n, N + 1);
    chk(done === 1 && locked === 0 && err === 0, "R8 done unlocked", {done, locked, err}, 4);
    for (int i = 0; i < N; i++) model[i] = '1;
    model[5] = 8'h5A;
    cfg_chk("R8 array contents");
    read_chk(5, 8'h5A, "R8 stored word");
    issue(3'd1, 5, 8'h00);
    chk(err === 1, "R8 stored word marked written", err, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule